// File: doc/BRIEF.md
# Link Event Derandomizer with Orbit Flush

This block buffers complete event records for a single optical link. A front-end announces each event with its bunch-crossing number and payload length, then delivers that many payload words. The block stores a one-word header followed by the payload in a circular word store. A downstream serializer drains the store one word at a time over a valid/ready interface, with markers on the first and last word of each record.

Space is checked when an event is announced. An event whose payload does not fit is stored as a header alone, with its length field forced to zero and a truncation flag set. An event that finds no room even for the header is discarded, and the next stored header carries a lost-event flag. A central hold input makes the block ignore new events.

An internal crossing counter runs over one orbit. When it reaches a configurable crossing near the end of the orbit's empty gap, the block clears its store. If anything was still held at that moment, a sticky error flag is raised.

Top module: `evd_link_buffer`

## Requirements
- R1: The first word of every record leaves with `out_sop` high and is a header holding the crossing number in bits [23:12], the stored payload length in bits [11:4] and the quality field in bits [3:0] (bit 0 = payload truncated, bit 1 = an earlier event was lost), with default widths.
- R2: The payload words leave in arrival order directly after their header, with `out_eop` high on the last one, or on the header when the length is zero. Data and markers hold steady while `out_valid` is high and `out_ready` is low.
- R3: An event needing more words (length + 1) than are free, while at least one word is free, is stored as a header with length 0 and quality bit 0 set, and its payload words are discarded. Stored words never exceed the store depth.
- R4: An event announced when no word is free is discarded entirely. The next stored header has quality bit 1 set, and that bit is cleared again afterwards.
- R5: While `wr_hold` is high, an announced event and its payload are ignored and nothing is written.
- R6: No word of a record is presented at the output before the last payload word of that record has been accepted.
- R7: In the cycle the crossing counter equals `FLUSH_BX`, all stored and in-flight words are discarded, and `out_valid` is low in the next cycle. If anything was held, `orbit_err` rises and stays high until reset. Records written after the flush are delivered normally.
- R8: A flush that finds the block empty leaves `orbit_err` low.
- R9: During and directly after reset, `out_valid` and `orbit_err` are low.
- R10: Several records written back to back leave in write order and intact, even when `out_ready` toggles irregularly.
- R11: The crossing counter starts at 0 after reset, advances every cycle and wraps after `ORBIT_LEN` values, so a flush occurs exactly once per orbit and not before the counter reaches `FLUSH_BX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hold | input | 1 | Central hold: ignore new events while high |
| ev_start | input | 1 | One-cycle announcement of a new event |
| ev_bxid | input | BX_W | Crossing number of the announced event |
| ev_len | input | LEN_W | Payload word count of the announced event |
| pl_valid | input | 1 | Payload word strobe |
| pl_data | input | DATA_W | Payload word |
| out_ready | input | 1 | Link side accepts the presented word |
| out_valid | output | 1 | A word is presented |
| out_data | output | DATA_W | Presented word (header or payload) |
| out_sop | output | 1 | Presented word is a record header |
| out_eop | output | 1 | Presented word ends its record |
| orbit_err | output | 1 | Sticky: a flush found the block non-empty |

## Verification
The bench builds the block with a 16-word store, a 256-crossing orbit and the flush at crossing 250. Each test can therefore run inside one orbit, and a full run covers more than twenty flushes. The small store lets the bench sweep every payload length from zero up to the one that exactly fills the store. It also makes the exact-fit, one-word-short and zero-room cases occur within four or five events. Because the orbit is short, the bench can find the flush cycle from its own cycle count and sample on both sides of it.

// File: rtl/evd_pkg.sv
package evd_pkg;
  // quality field bit positions inside a header word
  localparam int QB_TRUNC = 0;
  localparam int QB_LOST  = 1;

  typedef enum logic [1:0] {
    W_IDLE,
    W_BODY,
    W_DISCARD
  } wr_state_e;
endpackage

// File: rtl/evd_ram.sv
module evd_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/evd_writer.sv
module evd_writer
  import evd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 24,
  parameter int BX_W   = 12,
  parameter int LEN_W  = 8,
  parameter int Q_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_hold,
  input  logic              ev_start,
  input  logic [BX_W-1:0]   ev_bxid,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              pl_valid,
  input  logic [DATA_W-1:0] pl_data,
  input  logic [ADDR_W:0]   done_ptr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W:0]   wr_ptr,
  output logic [ADDR_W:0]   commit_ptr,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam int CW    = ((LEN_W > PW) ? LEN_W : PW) + 1;
  localparam int HW    = BX_W + LEN_W + Q_W;

  wr_state_e        state;
  logic [LEN_W-1:0] rem;
  logic             lost;

  logic [PW-1:0]    fill;
  logic [CW-1:0]    free_w, need_w;
  logic             fits, room, take;
  logic [Q_W-1:0]   hdr_q;
  logic [LEN_W-1:0] hdr_len;
  logic [HW-1:0]    hdr_raw;

  assign fill   = wr_ptr - done_ptr;
  assign free_w = CW'(DEPTH) - CW'(fill);
  assign need_w = CW'(ev_len) + CW'(1);
  assign fits   = need_w <= free_w;
  assign room   = free_w != '0;
  assign take   = (state == W_IDLE) && ev_start && !wr_hold;
  assign busy   = state == W_BODY;

  always_comb begin
    hdr_q           = '0;
    hdr_q[QB_TRUNC] = !fits;
    hdr_q[QB_LOST]  = lost;
  end

  assign hdr_len = fits ? ev_len : '0;
  assign hdr_raw = {ev_bxid, hdr_len, hdr_q};
  assign waddr   = wr_ptr[ADDR_W-1:0];

  always_comb begin
    we    = 1'b0;
    wdata = pl_data;
    if (take && room) begin
      we    = 1'b1;
      wdata = DATA_W'(hdr_raw);
    end else if (state == W_BODY && pl_valid) begin
      we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state      <= W_IDLE;
      rem        <= '0;
      lost       <= 1'b0;
      wr_ptr     <= '0;
      commit_ptr <= '0;
    end else begin
      case (state)
        W_IDLE: begin
          if (take) begin
            rem <= ev_len;
            if (!room) begin
              lost  <= 1'b1;
              state <= (ev_len != '0) ? W_DISCARD : W_IDLE;
            end else begin
              wr_ptr <= wr_ptr + 1'b1;
              lost   <= 1'b0;
              if (fits && ev_len != '0) begin
                state <= W_BODY;
              end else begin
                commit_ptr <= wr_ptr + 1'b1;
                state      <= (ev_len != '0) ? W_DISCARD : W_IDLE;
              end
            end
          end
        end
        W_BODY: begin
          if (pl_valid) begin
            wr_ptr <= wr_ptr + 1'b1;
            rem    <= rem - 1'b1;
            if (rem == LEN_W'(1)) begin
              commit_ptr <= wr_ptr + 1'b1;
              state      <= W_IDLE;
            end
          end
        end
        default: begin
          if (pl_valid) begin
            rem <= rem - 1'b1;
            if (rem == LEN_W'(1)) state <= W_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evd_reader.sv
module evd_reader #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 24,
  parameter int LEN_W  = 8,
  parameter int Q_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W:0]   commit_ptr,
  input  logic [DATA_W-1:0] ram_q,
  input  logic              out_ready,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   done_ptr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int EW = DATA_W + 2;

  logic [ADDR_W:0]  rd_ptr;
  logic             pending;
  logic [1:0]       occ, occ_n, slots;
  logic [EW-1:0]    e0, e1, e0_n, e1_n, ent;
  logic [LEN_W-1:0] rem, rem_n, fld_len;
  logic             pop, is_hdr;

  assign pop   = (occ != 2'd0) && out_ready;
  assign slots = occ + 2'(pending) - 2'(pop);
  assign re    = (rd_ptr != commit_ptr) && (slots < 2'd2);
  assign raddr = rd_ptr[ADDR_W-1:0];

  // tag the word returning from the store
  assign is_hdr  = rem == '0;
  assign fld_len = ram_q[Q_W +: LEN_W];
  assign ent     = {is_hdr, is_hdr ? (fld_len == '0) : (rem == LEN_W'(1)), ram_q};
  assign rem_n   = !pending ? rem : (is_hdr ? fld_len : rem - 1'b1);

  always_comb begin
    e0_n  = e0;
    e1_n  = e1;
    occ_n = occ;
    if (pop) begin
      e0_n  = e1;
      occ_n = occ - 2'd1;
    end
    if (pending) begin
      if (occ_n == 2'd0) e0_n = ent;
      else               e1_n = ent;
      occ_n = occ_n + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr   <= '0;
      done_ptr <= '0;
      pending  <= 1'b0;
      occ      <= 2'd0;
      rem      <= '0;
      e0       <= '0;
      e1       <= '0;
    end else begin
      pending <= re;
      if (re)  rd_ptr   <= rd_ptr + 1'b1;
      if (pop) done_ptr <= done_ptr + 1'b1;
      occ <= occ_n;
      e0  <= e0_n;
      e1  <= e1_n;
      rem <= rem_n;
    end
  end

  assign out_valid = occ != 2'd0;
  assign out_data  = e0[DATA_W-1:0];
  assign out_sop   = e0[EW-1];
  assign out_eop   = e0[EW-2];
endmodule

// File: rtl/evd_orbit.sv
module evd_orbit #(
  parameter int ORBIT_LEN = 3564,
  parameter int FLUSH_BX  = 3563
) (
  input  logic clk,
  input  logic rst,
  input  logic nonempty,
  output logic flush,
  output logic err
);
  localparam int CNT_W = $clog2(ORBIT_LEN);

  logic [CNT_W-1:0] cnt;

  assign flush = cnt == CNT_W'(FLUSH_BX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      cnt <= (cnt == CNT_W'(ORBIT_LEN - 1)) ? '0 : cnt + 1'b1;
      if (flush && nonempty) err <= 1'b1;
    end
  end
endmodule

// File: rtl/evd_link_buffer.sv
module evd_link_buffer #(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 24,
  parameter int BX_W      = 12,
  parameter int LEN_W     = 8,
  parameter int Q_W       = 4,
  parameter int ORBIT_LEN = 3564,
  parameter int FLUSH_BX  = 3563
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hold,
  input  logic              ev_start,
  input  logic [BX_W-1:0]   ev_bxid,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              pl_valid,
  input  logic [DATA_W-1:0] pl_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              orbit_err
);
  logic              orb_flush, wr_busy, nonempty;
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic [ADDR_W:0]   wr_ptr, commit_ptr, done_ptr;

  assign nonempty = (wr_ptr != done_ptr) || wr_busy;

  evd_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BX_W(BX_W), .LEN_W(LEN_W), .Q_W(Q_W)
  ) u_writer (
    .clk(clk), .rst(rst), .flush(orb_flush), .wr_hold(wr_hold),
    .ev_start(ev_start), .ev_bxid(ev_bxid), .ev_len(ev_len),
    .pl_valid(pl_valid), .pl_data(pl_data), .done_ptr(done_ptr),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .wr_ptr(wr_ptr), .commit_ptr(commit_ptr), .busy(wr_busy)
  );

  evd_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  evd_reader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .Q_W(Q_W)
  ) u_reader (
    .clk(clk), .rst(rst), .flush(orb_flush), .commit_ptr(commit_ptr),
    .ram_q(ram_q), .out_ready(out_ready), .re(ram_re), .raddr(ram_raddr),
    .done_ptr(done_ptr), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  evd_orbit #(.ORBIT_LEN(ORBIT_LEN), .FLUSH_BX(FLUSH_BX)) u_orbit (
    .clk(clk), .rst(rst), .nonempty(nonempty), .flush(orb_flush), .err(orbit_err)
  );
endmodule

// File: rtl/evd_link_buffer_chk.sv
module evd_link_buffer_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_hold,
  input logic              ev_start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              orbit_err,
  input logic              flush,
  input logic              ram_we,
  input logic              wr_busy,
  input logic [ADDR_W:0]   wr_ptr,
  input logic [ADDR_W:0]   done_ptr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W+1:0] fill_x;
  assign fill_x = {1'b0, wr_ptr - done_ptr};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill_x <= (ADDR_W+2)'(DEPTH)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    orbit_err |=> orbit_err); // R7

  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_hold && ev_start && !wr_busy |-> !ram_we); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid && !orbit_err); // R9
endmodule

bind evd_link_buffer evd_link_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_hold(wr_hold), .ev_start(ev_start),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop), .orbit_err(orbit_err),
  .flush(orb_flush), .ram_we(ram_we), .wr_busy(wr_busy),
  .wr_ptr(wr_ptr), .done_ptr(done_ptr)
);

// File: tb/evd_link_buffer_test.sv
`timescale 1ns/1ps
module evd_link_buffer_test;
  localparam int ADDR_W = 4, DATA_W = 24, BX_W = 12, LEN_W = 8, Q_W = 4;
  localparam int ORBIT = 256, FLUSH = 250;

  logic clk = 0, rst = 1, wr_hold = 0, ev_start = 0, pl_valid = 0, out_ready = 0;
  logic [BX_W-1:0]   ev_bxid = '0;
  logic [LEN_W-1:0]  ev_len = '0;
  logic [DATA_W-1:0] pl_data = '0;
  logic              out_valid, out_sop, out_eop, orbit_err;
  logic [DATA_W-1:0] out_data;

  int checks = 0, fails = 0, bc = 0, rmode = 0;
  bit feeding = 0, done = 0;
  logic [25:0] exp_q [512];
  int exp_wr = 0, exp_rd = 0;

  always #10 clk = ~clk;

  evd_link_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BX_W(BX_W), .LEN_W(LEN_W),
                    .Q_W(Q_W), .ORBIT_LEN(ORBIT), .FLUSH_BX(FLUSH)) uut (
    .clk(clk), .rst(rst), .wr_hold(wr_hold), .ev_start(ev_start), .ev_bxid(ev_bxid),
    .ev_len(ev_len), .pl_valid(pl_valid), .pl_data(pl_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .orbit_err(orbit_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) bc <= rst ? 0 : bc + 1;

  always @(posedge clk) begin
    #2;
    case (rmode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = (bc % 3) != 0;
    endcase
  end

  // monitor: sample half a cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (feeding && out_valid) chk(1'b0, "R6 early output", 32'(out_data), 32'h0);
      if (out_valid && out_ready) begin
        if (exp_rd == exp_wr) chk(1'b0, "R2/R7 unexpected word", 32'(out_data), 32'h0);
        else begin
          chk({out_sop, out_eop, out_data} == exp_q[exp_rd % 512], "R1/R2/R10 word",
              32'({out_sop, out_eop, out_data}), 32'(exp_q[exp_rd % 512]));
          exp_rd++;
        end
      end
    end
  end

  function automatic logic [23:0] hdr(input int bx, input int len, input int q);
    return 24'((bx << 12) | (len << 4) | q);
  endfunction

  task automatic exp_record(input int bx, input int len, input int q, input int base);
    exp_q[exp_wr % 512] = {1'b1, len == 0, hdr(bx, len, q)};
    exp_wr++;
    for (int i = 0; i < len; i++) begin
      exp_q[exp_wr % 512] = {1'b0, i == len - 1, 24'(base + i)};
      exp_wr++;
    end
  endtask

  task automatic send(input int bx, input int len, input int base, input bit gap);
    @(posedge clk); #2;
    ev_start = 1; ev_bxid = BX_W'(bx); ev_len = LEN_W'(len);
    @(posedge clk); #2;
    ev_start = 0;
    for (int i = 0; i < len; i++) begin
      if (gap && i > 0) begin pl_valid = 0; @(posedge clk); #2; end
      pl_valid = 1; pl_data = DATA_W'(base + i);
      @(posedge clk); #2;
    end
    pl_valid = 0;
    feeding = 0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_flush();
    do @(negedge clk); while ((bc % ORBIT) != FLUSH + 1);
  endtask

  task automatic drained(input string req);
    chk(exp_rd == exp_wr, req, 32'(exp_rd), 32'(exp_wr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'(bc), 32'h0);
      summary();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R9 out_valid", 32'(out_valid), 0);
    chk(orbit_err == 0, "R9 orbit_err", 32'(orbit_err), 0);

    // R1 R2 R6: every payload length up to an exactly full store
    for (int len = 0; len < 16; len++) begin
      wait_flush();
      rmode = 1;
      exp_record(len * 16 + 1, len, 0, len << 8);
      feeding = 1;
      send(len * 16 + 1, len, len << 8, 1'b1);
      wait_cycles(25);
      drained("R1/R2 length sweep");
    end

    // R3 R4: truncation, exact fit, zero-room drops, lost flag
    wait_flush();
    rmode = 0;
    exp_record(12'h101, 10, 0, 24'h1000);
    send(12'h101, 10, 24'h1000, 1'b0);
    exp_record(12'h102, 0, 1, 0);                 // R3 header only
    send(12'h102, 8, 24'h2000, 1'b0);
    exp_record(12'h103, 3, 0, 24'h3000);          // exact fit
    send(12'h103, 3, 24'h3000, 1'b0);
    send(12'h104, 2, 24'h4000, 1'b0);             // R4 dropped
    send(12'h105, 0, 24'h0, 1'b0);                // R4 dropped
    rmode = 1;
    wait_cycles(40);
    drained("R3 stored records");
    exp_record(12'h106, 1, 2, 24'h6000);          // R4 lost flag
    send(12'h106, 1, 24'h6000, 1'b0);
    exp_record(12'h107, 0, 0, 0);                 // R4 flag cleared
    send(12'h107, 0, 0, 1'b0);
    wait_cycles(15);
    drained("R4 lost flag");

    // R5: central hold
    wait_flush();
    wr_hold = 1;
    send(12'h0AA, 2, 24'h7000, 1'b0);
    wr_hold = 0;
    wait_cycles(10);
    chk(out_valid == 0, "R5 held event", 32'(out_valid), 0);
    exp_record(12'h0AB, 1, 0, 24'h7100);
    send(12'h0AB, 1, 24'h7100, 1'b0);
    wait_cycles(10);
    drained("R5 after hold");
    chk(orbit_err == 0, "R8 empty flushes", 32'(orbit_err), 0);

    // R7 R11: flush with stored data
    wait_flush();
    rmode = 0;
    send(12'h0D0, 2, 24'h8000, 1'b0);
    do @(negedge clk); while ((bc % ORBIT) != FLUSH);
    chk(out_valid == 1, "R11 no early flush", 32'(out_valid), 1);
    chk(orbit_err == 0, "R11 no early error", 32'(orbit_err), 0);
    @(negedge clk);
    chk(out_valid == 0, "R7 flushed", 32'(out_valid), 0);
    chk(orbit_err == 1, "R7 error raised", 32'(orbit_err), 1);
    rmode = 1;
    wait_cycles(10);
    drained("R7 nothing left");
    exp_record(12'h0D1, 2, 0, 24'h8100);
    send(12'h0D1, 2, 24'h8100, 1'b0);
    wait_cycles(15);
    drained("R7 restart");

    // R10: back-to-back records with irregular ready
    wait_flush();
    rmode = 2;
    exp_record(12'h0E1, 1, 0, 24'h9000);
    send(12'h0E1, 1, 24'h9000, 1'b0);
    exp_record(12'h0E2, 3, 0, 24'h9100);
    send(12'h0E2, 3, 24'h9100, 1'b0);
    exp_record(12'h0E3, 0, 0, 0);
    send(12'h0E3, 0, 0, 1'b0);
    exp_record(12'h0E4, 5, 0, 24'h9200);
    send(12'h0E4, 5, 24'h9200, 1'b0);
    wait_cycles(40);
    drained("R10 ordering");
    chk(orbit_err == 1, "R7 sticky", 32'(orbit_err), 1);

    done = 1;
    summary();
  end
endmodule